// File: doc/BRIEF.md
# Block-Lock Write Protection Controller

This block is the write-permission and status authority of a small serial nonvolatile memory. A separate command engine handles serial shifting and array storage. It reports decoded events here: commands that set or clear the write-enable latch, and commit requests raised when a chip-select window closes on a valid count. A commit is either an array page write, which carries the page index, or a status write, which carries one data byte. The block decides whether each commit may proceed. For an accepted commit it runs a self-timed write cycle and updates the protection bits. It also supplies the status byte that the engine shifts out on a status read.

Three mechanisms combine to guard a write. The first is the write-enable latch, which must be set before any write and which clears itself at the end of every write cycle. The second is a two-bit lock field that fences off the upper quarter, the upper half or the whole array; a page inside the fenced range is never written. The third is an external protect pin. It guards the status register only while the stored pin-enable bit is 1. If that pin drops at any point during the selection that carries a status write, the write is aborted.

Top module: `wpc_blocklock_ctrl`

## Requirements
- R1: When no write cycle runs, `status_byte` reads bit 7 = pin-enable bit, bits 6..4 = 0, bits 3..2 = lock field (bit 3 high half), bit 1 = write-enable latch, bit 0 = 0. After reset, it reads 0x00.
- R2: A `wel_set` pulse sets the latch and a `wel_clr` pulse clears it. If both pulses arrive in the same cycle, the clear wins. A latch command that arrives in a cycle that also carries a commit is ignored.
- R3: While the latch is clear, no commit is accepted: `arr_go` and `sts_go` stay low and the stored bits do not change.
- R4: Lock field 00 locks no page. Field 01 locks the pages whose two top index bits are 11 (bytes 0x600 to 0x7FF). Field 10 locks the pages whose top index bit is 1 (bytes 0x400 to 0x7FF). Field 11 locks every page. An array commit to a locked page is rejected as a whole and starts no cycle, whatever the state of the pin, the pin-enable bit and the latch.
- R5: Hardware protection is active when `lock_pin_n` is 0 and the pin-enable bit is 1. While it is active, a status commit is rejected. Array commits to unlocked pages are still accepted.
- R6: If hardware protection is active in any cycle while `sel_active` is high, the status commit that closes that selection is rejected, even if the pin has returned high. The pin has no effect on a write cycle that has already started.
- R7: An accepted commit holds `write_busy` high for exactly CYCLE_TICKS cycles. During that time `status_byte` reads 0xFF. `cycle_done` pulses in the last busy cycle.
- R8: The latch reads 0 after every completed write cycle, whether it was an array write or a status write.
- R9: An accepted status write stores data bit 7 as the pin-enable bit and data bits 3..2 as the lock field. All other data bits are ignored.
- R10: While a write cycle runs, commits and latch commands are ignored.
- R11: When an array commit and a status commit arrive in the same cycle, only the array commit is considered and the status commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_pin_n | input | 1 | External protect pin, low = protect |
| sel_active | input | 1 | Chip select currently asserted on the serial side |
| arr_commit | input | 1 | Array page write commit pulse |
| arr_page | input | PAGE_IDX_W | Page index of the array commit |
| sts_commit | input | 1 | Status write commit pulse |
| sts_data | input | 8 | Data byte of the status commit |
| wel_set | input | 1 | Set the write-enable latch |
| wel_clr | input | 1 | Clear the write-enable latch |
| status_byte | output | 8 | Status byte for reads |
| write_busy | output | 1 | Self-timed write cycle running |
| arr_go | output | 1 | Array commit accepted this cycle |
| sts_go | output | 1 | Status commit accepted this cycle |
| cycle_done | output | 1 | Last cycle of the write cycle |

## Verification
The bench builds the block with CYCLE_TICKS = 12 and the default 11-bit address and 32-byte page. With a 12-tick write cycle, several thousand random cycles include many complete write cycles. In that run, latch commands, commits and pin drops often land inside a busy window, and the self-clearing of the latch is exercised over and over. The default page-index width keeps the quarter boundaries at the true byte addresses, so the directed lock-range cases test the real fences.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  // Nonvolatile protection bits held by the controller
  typedef struct packed {
    logic       pin_en;
    logic [1:0] lock;
  } wpc_nv_t;

  localparam int STS_PINEN_BIT = 7;
  localparam int STS_LOCK_LSB  = 2;
  localparam int STS_WEL_BIT   = 1;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } wpc_lock_e;

endpackage

// File: rtl/wpc_lock_decode.sv
module wpc_lock_decode
  import wpc_pkg::*;
#(
  parameter int PAGE_IDX_W = 6
) (
  input  logic [1:0]            lock,
  input  logic [PAGE_IDX_W-1:0] page,
  output logic                  locked
);

  logic [1:0] quarter;
  assign quarter = page[PAGE_IDX_W-1 -: 2];

  always_comb begin
    unique case (wpc_lock_e'(lock))
      LOCK_NONE:    locked = 1'b0;
      LOCK_QUARTER: locked = (quarter == 2'b11);
      LOCK_HALF:    locked = quarter[1];
      default:      locked = 1'b1;
    endcase
  end

endmodule

// File: rtl/wpc_guard.sv
module wpc_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_pin_n,
  input  logic pin_en,
  input  logic sel_active,
  output logic hw_prot,
  output logic sts_blocked
);

  logic taint_q, taint_d;

  assign hw_prot = pin_en & ~lock_pin_n;

  always_comb begin
    taint_d = sel_active ? (taint_q | hw_prot) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taint_q <= 1'b0;
    else        taint_q <= taint_d;
  end

  assign sts_blocked = taint_q | hw_prot;

  AST_PIN_DROP_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_active && hw_prot) |=> sts_blocked); // R6

endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
  parameter int CYCLE_TICKS = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (CYCLE_TICKS > 2) ? $clog2(CYCLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLE_TICKS - 1);

  logic             busy_q, busy_d, busy_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d  = busy_q;
    busy_en = 1'b0;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start && !busy_q) begin
      busy_d  = 1'b1;
      busy_en = 1'b1;
      cnt_d   = LOAD_VAL;
      cnt_en  = 1'b1;
    end else if (done) begin
      busy_d  = 1'b0;
      busy_en = 1'b1;
    end else if (busy_q) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (busy_en) busy_q <= busy_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q); // R7

endmodule

// File: rtl/wpc_blocklock_ctrl.sv
module wpc_blocklock_ctrl
  import wpc_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES_W = 5,
  parameter int CYCLE_TICKS  = 250000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             lock_pin_n,
  input  logic                             sel_active,
  input  logic                             arr_commit,
  input  logic [ADDR_W-PAGE_BYTES_W-1:0]   arr_page,
  input  logic                             sts_commit,
  input  logic [7:0]                       sts_data,
  input  logic                             wel_set,
  input  logic                             wel_clr,
  output logic [7:0]                       status_byte,
  output logic                             write_busy,
  output logic                             arr_go,
  output logic                             sts_go,
  output logic                             cycle_done
);

  localparam int PAGE_IDX_W = ADDR_W - PAGE_BYTES_W;

  // Reset: asserted asynchronously, released after two clock edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wpc_nv_t nv_q, nv_d;
  logic    nv_en;
  logic    wel_q, wel_d, wel_en;
  logic    arr_locked, hw_prot, sts_blocked;
  logic    busy, done, start, idle, any_commit;
  logic    sts_data_unused;

  assign sts_data_unused = ^{sts_data[6:4], sts_data[1:0]};

  wpc_lock_decode #(.PAGE_IDX_W(PAGE_IDX_W)) u_lock (
    .lock   (nv_q.lock),
    .page   (arr_page),
    .locked (arr_locked)
  );

  wpc_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .lock_pin_n  (lock_pin_n),
    .pin_en      (nv_q.pin_en),
    .sel_active  (sel_active),
    .hw_prot     (hw_prot),
    .sts_blocked (sts_blocked)
  );

  wpc_cycle_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  assign idle       = ~busy;
  assign any_commit = arr_commit | sts_commit;
  assign arr_go     = idle & arr_commit & wel_q & ~arr_locked;
  assign sts_go     = idle & ~arr_commit & sts_commit & wel_q & ~sts_blocked;
  assign start      = arr_go | sts_go;

  always_comb begin
    nv_d  = nv_q;
    nv_en = 1'b0;
    if (sts_go) begin
      nv_d.pin_en = sts_data[STS_PINEN_BIT];
      nv_d.lock   = sts_data[STS_LOCK_LSB +: 2];
      nv_en       = 1'b1;
    end
  end

  always_comb begin
    wel_d  = wel_q;
    wel_en = 1'b0;
    if (done) begin
      wel_d  = 1'b0;
      wel_en = 1'b1;
    end else if (idle && !any_commit && (wel_clr || wel_set)) begin
      wel_d  = ~wel_clr;
      wel_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      nv_q  <= '0;
      wel_q <= 1'b0;
    end else begin
      if (nv_en)  nv_q  <= nv_d;
      if (wel_en) wel_q <= wel_d;
    end
  end

  always_comb begin
    if (busy) begin
      status_byte = 8'hFF;
    end else begin
      status_byte = '0;
      status_byte[STS_PINEN_BIT]        = nv_q.pin_en;
      status_byte[STS_LOCK_LSB +: 2]    = nv_q.lock;
      status_byte[STS_WEL_BIT]          = wel_q;
    end
  end

  assign write_busy = busy;
  assign cycle_done = done;

  AST_GO_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (arr_go || sts_go) |-> wel_q); // R3
  AST_NO_LOCKED_PAGE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    arr_go |-> !arr_locked); // R4
  AST_HW_BLOCKS_STATUS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    sts_go |-> !hw_prot); // R5
  AST_LATCH_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    cycle_done |=> !wel_q); // R8
  AST_NV_ONLY_BY_STATUS: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !sts_go |=> $stable(nv_q)); // R9
  AST_NO_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_q)
    write_busy |-> !(arr_go || sts_go)); // R10

endmodule

// File: tb/wpc_blocklock_ctrl_tb.sv
module wpc_blocklock_ctrl_tb;

  localparam int TICKS = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       lock_pin_n, sel_active, arr_commit, sts_commit, wel_set, wel_clr;
  logic [5:0] arr_page;
  logic [7:0] sts_data, status_byte;
  logic       write_busy, arr_go, sts_go, cycle_done;

  always #2 clk = ~clk;

  wpc_blocklock_ctrl #(.CYCLE_TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .lock_pin_n(lock_pin_n), .sel_active(sel_active),
    .arr_commit(arr_commit), .arr_page(arr_page), .sts_commit(sts_commit),
    .sts_data(sts_data), .wel_set(wel_set), .wel_clr(wel_clr),
    .status_byte(status_byte), .write_busy(write_busy), .arr_go(arr_go),
    .sts_go(sts_go), .cycle_done(cycle_done)
  );

  int n_run = 0, n_fail = 0;
  bit m_pinen, m_wel, m_taint;
  bit [1:0] m_lock;
  int m_left;
  bit finished = 0;

  function automatic bit f_locked(bit [1:0] lk, bit [5:0] pg);
    case (lk)
      2'b00: return 1'b0;
      2'b01: return pg[5:4] == 2'b11;
      2'b10: return pg[5];
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit [7:0] f_status();
    if (m_left > 0) return 8'hFF;
    return {m_pinen, 3'b000, m_lock, m_wel, 1'b0};
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit pin, input bit sel, input bit ac, input bit [5:0] pg,
                      input bit sc, input bit [7:0] sd, input bit ws, input bit wc);
    bit busy, hw, lk, a_ok, s_ok, n_taint;
    string ta, ts;
    lock_pin_n = pin; sel_active = sel; arr_commit = ac; arr_page = pg;
    sts_commit = sc; sts_data = sd; wel_set = ws; wel_clr = wc;
    #2;
    busy = (m_left > 0);
    hw   = !pin && m_pinen;
    lk   = f_locked(m_lock, pg);
    a_ok = !busy && ac && m_wel && !lk;
    s_ok = !busy && !ac && sc && m_wel && !hw && !m_taint;
    ta = busy ? "R10" : (!m_wel ? "R3" : "R4");
    ts = busy ? "R10" : (ac ? "R11" : (!m_wel ? "R3" : (hw ? "R5" : (m_taint ? "R6" : "R9"))));
    chk("R7", "write_busy", {7'b0, write_busy}, {7'b0, busy});
    chk(busy ? "R7" : "R1", "status_byte", status_byte, f_status());
    chk(ta, "arr_go", {7'b0, arr_go}, {7'b0, a_ok});
    chk(ts, "sts_go", {7'b0, sts_go}, {7'b0, s_ok});
    chk("R7", "cycle_done", {7'b0, cycle_done}, {7'b0, m_left == 1});
    n_taint = sel ? (m_taint | hw) : 1'b0;
    if (busy) begin
      m_left--;
      if (m_left == 0) m_wel = 1'b0;
    end else if (a_ok || s_ok) begin
      m_left = TICKS;
      if (s_ok) begin m_pinen = sd[7]; m_lock = sd[3:2]; end
    end else if (!ac && !sc) begin
      if (wc) m_wel = 1'b0;
      else if (ws) m_wel = 1'b1;
    end
    m_taint = n_taint;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n, input bit pin);
    for (int i = 0; i < n; i++) step(pin, 0, 0, 6'd0, 0, 8'd0, 0, 0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit sel_r;
    void'($urandom(32'h0C0FFEE5));
    rst_n = 1'b0; lock_pin_n = 1; sel_active = 0; arr_commit = 0; arr_page = 0;
    sts_commit = 0; sts_data = 0; wel_set = 0; wel_clr = 0;
    m_pinen = 0; m_lock = 0; m_wel = 0; m_taint = 0; m_left = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset status", status_byte, 8'h00);

    step(1, 0, 0, 0, 0, 0, 1, 0);
    chk("R2", "latch set", status_byte, 8'h02);
    step(1, 0, 0, 0, 0, 0, 1, 1);
    chk("R2", "clear wins", status_byte, 8'h00);
    step(1, 1, 1, 6'h00, 0, 0, 0, 0);              // R3: latch clear, commit ignored
    idle(1, 1);
    chk("R3", "no change", status_byte, 8'h00);

    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 1, 0, 0, 1, 8'hFF, 0, 0);
    chk("R7", "busy reads ones", status_byte, 8'hFF);
    idle(TICKS, 1);
    chk("R9", "only bits 7,3,2 stored", status_byte, 8'h8C);
    chk("R8", "latch cleared after status write", {7'b0, status_byte[1]}, 8'h00);

    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 1, 1, 6'h00, 0, 0, 0, 0);              // R4: whole array locked
    chk("R4", "locked page rejected", {7'b0, write_busy}, 8'h00);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 1, 8'h00, 0, 0);              // R5: pin low, pin-enable set
    chk("R5", "status protected", status_byte, 8'h8E);
    idle(1, 1);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 1, 8'h00, 0, 0);              // R6: earlier pin drop aborts
    chk("R6", "aborted by earlier pin drop", status_byte, 8'h8E);
    idle(1, 1);
    step(1, 1, 0, 0, 1, 8'h04, 0, 0);
    idle(TICKS, 0);                                // R6: pin low during cycle
    chk("R6", "pin ignored once started", status_byte, 8'h04);

    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(1, 1, 1, 6'h30, 0, 0, 0, 0);              // top quarter locked
    chk("R4", "quarter locked", {7'b0, write_busy}, 8'h00);
    step(1, 1, 1, 6'h2F, 1, 8'h8C, 0, 0);          // R11: array wins
    idle(TICKS, 1);
    chk("R11", "status commit dropped", status_byte, 8'h04);

    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(0, 1, 0, 0, 1, 8'h80, 0, 0);              // pin-enable 0: pin ignored
    idle(TICKS, 1);
    chk("R5", "pin inert while enable clear", status_byte, 8'h80);
    step(1, 0, 0, 0, 0, 0, 1, 0);
    step(0, 1, 1, 6'h3F, 0, 0, 0, 0);              // R5: array still writable
    chk("R5", "array write under pin", {7'b0, write_busy}, 8'h01);
    step(1, 0, 0, 0, 0, 0, 1, 0);                  // R10: set ignored while busy
    idle(TICKS - 1, 1);
    chk("R10", "latch cmd ignored in cycle", status_byte, 8'h80);

    sel_r = 0;
    for (int i = 0; i < 5000; i++) begin
      bit ac, sc;
      if (($urandom % 6) == 0) sel_r = ~sel_r;
      ac = (($urandom % 8) == 0);
      sc = (($urandom % 6) == 0);
      step(($urandom % 12) != 0, sel_r, ac, 6'($urandom), sc, 8'($urandom),
           ($urandom % 3) == 0, ($urandom % 14) == 0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule